// File: doc/BRIEF.md
# Interrupt Acknowledge Read Bridge

This block serves a host processor that has no way to run interrupt-acknowledge cycles of its own. The host does an ordinary read from one reserved address. The bridge turns that read into a full acknowledge handshake toward an attached priority interrupt controller, and it stalls the read until the handshake is over. The handshake is two active-low acknowledge strobes. During the second strobe the controller drives its 8-bit vector onto the data lines. The bridge latches that byte and returns it as the read data.

Some controllers are cascaded. If the byte from the primary controller shows that its winning input is the cascade input, the bridge then runs a second two-strobe handshake on a separate strobe toward the secondary controller, and returns the secondary vector instead. A read of any other address takes no part in acknowledge work. It is answered after one wait state with zero data.

The controller is a single state machine with these states:
- `ST_IDLE`: waiting for a read.
- `ST_P_STRB1`, `ST_P_GAP`, `ST_P_STRB2`: primary strobe, gap, primary strobe.
- `ST_S_LEAD`, `ST_S_STRB1`, `ST_S_GAP`, `ST_S_STRB2`: gap, secondary strobe, gap, secondary strobe.
- `ST_RESP`: vector response.
- `ST_MISS`: stray-read response.

The transitions are:
- idle→primary strobe on a matching read.
- idle→miss on a read of any other address.
- strobe→gap when the pulse counter expires.
- gap→strobe when the gap counter expires.
- last primary strobe→lead gap when the cascade is detected, otherwise →response.
- last secondary strobe→response.
- response or miss→idle, always.

Top module: `iack_read_bridge`

## Requirements
- R1: While reset is held, `rd_ready` is 0 and both strobes `ack_n` and `ack2_n` are 1.
- R2: A read request sampled in idle with `rd_addr == ACK_ADDR` pulls `ack_n` low starting in the next cycle. `ack_n` gives exactly two low pulses of `PULSE_W` cycles each (default 4), with `GAP_W` high cycles between them (default 2, at least 2).
- R3: A read request sampled in idle at any other address produces no strobe. It is answered in the next cycle with `rd_ready` = 1 and `rd_data` = 0.
- R4: The vector is taken from `vec_in` in the last cycle of the second primary pulse, and only then. Values on `vec_in` in every other cycle do not affect the returned data.
- R5: `rd_ready` stays 0 until the vector has been taken. It is then 1 for exactly one cycle, carrying the vector, with both strobes high. Without a cascade this is cycle 2·`PULSE_W`+`GAP_W`+1 after the accepting edge.
- R6: If bits [2:0] of the captured primary byte equal `CASCADE_IN` (default 2), the following happens. After `GAP_W` high cycles, `ack2_n` gives two low pulses of `PULSE_W` cycles each, separated by `GAP_W` high cycles. `vec2_in` is sampled in the last cycle of the second of these pulses, and that byte is returned. `ack_n` and `ack2_n` are never low together. `ack2_n` stays high on a non-cascade acknowledge.
- R7: A request held high while a sequence is in progress does not restart it. After the response cycle the block spends one idle cycle, and only then accepts the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | ADDR_W | Read address, stable while `rd_req` is high |
| rd_ready | output | 1 | One-cycle read completion |
| rd_data | output | 8 | Read data, valid with `rd_ready` |
| ack_n | output | 1 | Acknowledge strobe to the primary controller, active low |
| vec_in | input | 8 | Data lines driven by the primary controller |
| ack2_n | output | 1 | Acknowledge strobe to the secondary controller, active low |
| vec2_in | input | 8 | Data lines driven by the secondary controller |

## Verification
The checker relies on the host keeping its side of the request/ready handshake: `rd_req` and `rd_addr` must stay stable from the cycle the request is raised until the cycle `rd_ready` is seen. It also relies on the controllers presenting a settled vector in the sampling cycle. The bench host tasks release or change a request only after seeing `rd_ready`. The bench drives the true vector onto each data input only in the cycle its model marks as the sampling cycle. In every other cycle it drives changing junk, and that junk often carries the cascade code in its low bits.

// File: rtl/iack_pkg.sv
package iack_pkg;

    localparam int VEC_W = 8;
    localparam int SEL_W = 3;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_P_STRB1 = 4'd1,
        ST_P_GAP   = 4'd2,
        ST_P_STRB2 = 4'd3,
        ST_S_LEAD  = 4'd4,
        ST_S_STRB1 = 4'd5,
        ST_S_GAP   = 4'd6,
        ST_S_STRB2 = 4'd7,
        ST_RESP    = 4'd8,
        ST_MISS    = 4'd9
    } ack_state_e;

endpackage

// File: rtl/iack_addr_match.sv
module iack_addr_match #(
    parameter int          ADDR_W = 16,
    parameter logic [ADDR_W-1:0] MATCH = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = (addr == MATCH);
    end
endmodule

// File: rtl/iack_phase_ctr.sv
module iack_phase_ctr #(
    parameter int PULSE_W = 4,
    parameter int GAP_W   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic pulse_last,
    output logic gap_last
);
    localparam int MAX_W = (PULSE_W > GAP_W) ? PULSE_W : GAP_W;
    localparam int CW    = $clog2(MAX_W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        pulse_last = (cnt_q == CW'(PULSE_W - 1));
        gap_last   = (cnt_q == CW'(GAP_W - 1));
    end
endmodule

// File: rtl/iack_vec_latch.sv
module iack_vec_latch
    import iack_pkg::*;
#(
    parameter int CASCADE_IN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_pri,
    input  logic take_sec,
    input  vec_t vec_in,
    input  vec_t vec2_in,
    output logic pri_is_casc,
    output vec_t vec_q
);
    always_comb begin
        pri_is_casc = (vec_in[SEL_W-1:0] == SEL_W'(CASCADE_IN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (take_sec) begin
            vec_q <= vec2_in;
        end else if (take_pri) begin
            vec_q <= vec_in;
        end
    end
endmodule

// File: rtl/iack_read_bridge.sv
module iack_read_bridge
    import iack_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] ACK_ADDR   = 16'h0F00,
    parameter int                PULSE_W    = 4,
    parameter int                GAP_W      = 2,
    parameter int                CASCADE_IN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              ack_n,
    input  logic [7:0]        vec_in,
    output logic              ack2_n,
    input  logic [7:0]        vec2_in
);
    ack_state_e state_q, state_d;
    logic       addr_hit;
    logic       pulse_last, gap_last;
    logic       restart;
    logic       take_pri, take_sec;
    logic       pri_is_casc;
    vec_t       vec_q;

    iack_addr_match #(
        .ADDR_W (ADDR_W),
        .MATCH  (ACK_ADDR)
    ) u_match (
        .addr (rd_addr),
        .hit  (addr_hit)
    );

    iack_phase_ctr #(
        .PULSE_W (PULSE_W),
        .GAP_W   (GAP_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .pulse_last (pulse_last),
        .gap_last   (gap_last)
    );

    iack_vec_latch #(
        .CASCADE_IN (CASCADE_IN)
    ) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_pri    (take_pri),
        .take_sec    (take_sec),
        .vec_in      (vec_in),
        .vec2_in     (vec2_in),
        .pri_is_casc (pri_is_casc),
        .vec_q       (vec_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) begin
                    state_d = addr_hit ? ST_P_STRB1 : ST_MISS;
                end
            end
            ST_P_STRB1: if (pulse_last) state_d = ST_P_GAP;
            ST_P_GAP:   if (gap_last)   state_d = ST_P_STRB2;
            ST_P_STRB2: begin
                if (pulse_last) begin
                    state_d = pri_is_casc ? ST_S_LEAD : ST_RESP;
                end
            end
            ST_S_LEAD:  if (gap_last)   state_d = ST_S_STRB1;
            ST_S_STRB1: if (pulse_last) state_d = ST_S_GAP;
            ST_S_GAP:   if (gap_last)   state_d = ST_S_STRB2;
            ST_S_STRB2: if (pulse_last) state_d = ST_RESP;
            ST_RESP:    state_d = ST_IDLE;
            ST_MISS:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and phase control
    always_comb begin
        restart  = (state_d != state_q) || (state_q == ST_IDLE);
        take_pri = (state_q == ST_P_STRB2) && pulse_last;
        take_sec = (state_q == ST_S_STRB2) && pulse_last;
        ack_n    = !((state_q == ST_P_STRB1) || (state_q == ST_P_STRB2));
        ack2_n   = !((state_q == ST_S_STRB1) || (state_q == ST_S_STRB2));
        rd_ready = (state_q == ST_RESP) || (state_q == ST_MISS);
        rd_data  = (state_q == ST_RESP) ? vec_q : 8'h00;
    end
endmodule

// File: rtl/iack_read_bridge_chk.sv
module iack_read_bridge_chk #(
    parameter int PULSE_W = 4,
    parameter int GAP_W   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic rd_req,
    input logic rd_ready,
    input logic ack_n,
    input logic ack2_n
);
    localparam int RW = $clog2(PULSE_W + GAP_W + 2) + 1;
    localparam logic [RW-1:0] RMAX = '1;

    logic [RW-1:0] low1_q, low2_q, high_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low1_q <= '0;
            low2_q <= '0;
            high_q <= RMAX;
        end else begin
            low1_q <= !ack_n  ? ((low1_q == RMAX) ? RMAX : low1_q + 1'b1) : '0;
            low2_q <= !ack2_n ? ((low2_q == RMAX) ? RMAX : low2_q + 1'b1) : '0;
            high_q <= (ack_n && ack2_n) ? ((high_q == RMAX) ? RMAX : high_q + 1'b1) : '0;
        end
    end

    AST_PRI_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |-> (low1_q == RW'(PULSE_W)));                       // R2
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_n) || $fell(ack2_n)) |-> (high_q >= RW'(GAP_W)));       // R2
    AST_SEC_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack2_n) |-> (low2_q == RW'(PULSE_W)));                      // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> ack2_n);                                                // R6
    AST_READY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);                                           // R5
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> (ack_n && ack2_n));                                   // R5
    AST_READY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> rd_req);                                              // R7
endmodule

bind iack_read_bridge iack_read_bridge_chk #(
    .PULSE_W (PULSE_W),
    .GAP_W   (GAP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_ready (rd_ready),
    .ack_n    (ack_n),
    .ack2_n   (ack2_n)
);

// File: tb/test_iack_read_bridge.sv
module test_iack_read_bridge;
    localparam int          CLK_P    = 10;
    localparam int          PW       = 4;
    localparam int          GW       = 2;
    localparam int          CASC     = 2;
    localparam logic [15:0] ACK_ADDR = 16'h0F00;

    typedef struct {
        bit         s1;
        bit         s2;
        bit         rdy;
        logic [7:0] dat;
        bit         cap1;
        bit         cap2;
        logic [7:0] v;
        string      tag;
    } step_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        rd_ready;
    logic [7:0]  rd_data;
    logic        ack_n, ack2_n;
    logic [7:0]  vec_in = '0;
    logic [7:0]  vec2_in = '0;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    bit          finished = 0;
    logic [7:0]  tb_v1, tb_v2;
    string       tb_tag = "";
    step_t       q[$];

    iack_read_bridge #(
        .ADDR_W     (16),
        .ACK_ADDR   (ACK_ADDR),
        .PULSE_W    (PW),
        .GAP_W      (GW),
        .CASCADE_IN (CASC)
    ) i_iack_read_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .ack_n    (ack_n),
        .vec_in   (vec_in),
        .ack2_n   (ack2_n),
        .vec2_in  (vec2_in)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic push(input bit s1, input bit s2, input bit rdy, input logic [7:0] dat,
                        input bit c1, input bit c2, input logic [7:0] v, input string tag);
        step_t st;
        st.s1 = s1; st.s2 = s2; st.rdy = rdy; st.dat = dat;
        st.cap1 = c1; st.cap2 = c2; st.v = v;
        st.tag = (tb_tag != "") ? tb_tag : tag;
        q.push_back(st);
    endtask

    // Expected future of one accepted hit read
    task automatic plan_hit(input logic [7:0] v1, input logic [7:0] v2);
        for (int i = 0; i < PW; i++) push(0, 1, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < GW; i++) push(1, 1, 0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < PW - 1; i++) push(0, 1, 0, 0, 0, 0, 0, "R2");
        push(0, 1, 0, 0, 1, 0, v1, "R4");
        if (v1[2:0] == 3'(CASC)) begin
            for (int i = 0; i < GW; i++) push(1, 1, 0, 0, 0, 0, 0, "R6");
            for (int i = 0; i < PW; i++) push(1, 0, 0, 0, 0, 0, 0, "R6");
            for (int i = 0; i < GW; i++) push(1, 1, 0, 0, 0, 0, 0, "R6");
            for (int i = 0; i < PW - 1; i++) push(1, 0, 0, 0, 0, 0, 0, "R6");
            push(1, 0, 0, 0, 0, 1, v2, "R6");
            push(1, 1, 1, v2, 0, 0, 0, "R6");
        end else begin
            push(1, 1, 1, v1, 0, 0, 0, "R4");
        end
    endtask

    // Cycle-by-cycle reference model and comparison
    always @(negedge clk) begin
        step_t cur;
        bit    have;
        logic [7:0] junk;
        cyc++;
        junk = 8'h5A ^ cyc[7:0];
        if (!rst_n) begin
            vec_in  = junk;
            vec2_in = ~junk;
            chk(ack_n === 1'b1 && ack2_n === 1'b1, "R1", "strobes in reset", {ack_n, ack2_n}, 2'b11);
            chk(rd_ready === 1'b0, "R1", "ready in reset", rd_ready, 0);
        end else begin
            have = (q.size() > 0);
            if (have) begin
                cur = q.pop_front();
            end else begin
                cur.s1 = 1; cur.s2 = 1; cur.rdy = 0; cur.dat = 0;
                cur.cap1 = 0; cur.cap2 = 0; cur.v = 0; cur.tag = "R7";
            end
            vec_in  = cur.cap1 ? cur.v : junk;
            vec2_in = cur.cap2 ? cur.v : ~junk;
            chk(ack_n === cur.s1, cur.tag, "ack_n", ack_n, cur.s1);
            chk(ack2_n === cur.s2, (cur.tag == "R4") ? "R6" : cur.tag, "ack2_n", ack2_n, cur.s2);
            chk(rd_ready === cur.rdy, "R5", "rd_ready", rd_ready, cur.rdy);
            if (cur.rdy) begin
                chk(rd_data === cur.dat, cur.tag, "rd_data", rd_data, cur.dat);
            end
            if (!have && rd_req) begin
                if (rd_addr == ACK_ADDR) plan_hit(tb_v1, tb_v2);
                else push(1, 1, 1, 8'h00, 0, 0, 0, "R3");
            end
        end
    end

    task automatic do_read(input logic [15:0] a, input logic [7:0] p, input logic [7:0] s,
                           input string tag, input bit hold);
        tb_v1   = p;
        tb_v2   = s;
        tb_tag  = tag;
        rd_addr = a;
        rd_req  = 1'b1;
        do @(negedge clk); while (rd_ready !== 1'b1);
        @(posedge clk);
        #1;
        if (!hold) rd_req = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        gap(2);
        do_read(ACK_ADDR, 8'h41, 8'h00, "", 0);          // R2 R4 R5 plain
        gap(2);
        do_read(16'h0F01, 8'h42, 8'h00, "", 0);          // R3 stray read
        gap(1);
        do_read(ACK_ADDR, 8'h22, 8'h7D, "", 0);          // R6 cascade
        gap(3);
        do_read(ACK_ADDR, 8'h27, 8'h33, "", 0);          // R4 irq 7, no cascade
        gap(1);
        do_read(16'h0000, 8'h22, 8'h11, "R3", 1);        // R7 stray then held hit
        do_read(ACK_ADDR, 8'hA0, 8'h55, "R7", 1);        // R7 back to back
        do_read(ACK_ADDR, 8'h6A, 8'hC9, "R7", 0);        // R7 cascade after held
        gap(2);
        do_read(ACK_ADDR, 8'hFA, 8'h8E, "", 0);          // R6 all-ones upper bits
        gap(4);
        tb_tag = "";
        chk(q.size() == 0, "R5", "model drained", q.size(), 0);
        finish_run();
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog expired actual=%0d expected<=%0d", cyc, 20000);
            finish_run();
        end
    end
endmodule